// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block is a write-only configuration port driven over a three-wire serial link: an active-low select, a serial clock and a serial data line. A host shifts in 16-bit frames least significant bit first. The first byte carries the target device address, a channel-select bit and one reserved bit. The second byte carries the new contents of that channel's control register. The port accepts a frame only when the address field equals the six strapped address pins. Several devices can therefore share one serial bus.

Each channel has one control register. Its fields are a power-down flag, an algorithm-reset request, a bypass flag, a data-format flag and a 4-bit coding select. The fields drive the datapath directly. The algorithm-reset request stays set until the datapath reports completion for that channel, and the block then clears it. When every channel is powered down, the standby output is raised.

The serial clock, select and data lines are asynchronous to the system clock. Each passes through a two-flop synchroniser, and serial clock edges are detected in the system clock domain.

Top module: `serial_cfg_port`

## Requirements
- R1: While `rst_n` is low, every control field of every channel is 0 and `standby` is 0.
- R2: A frame updates a register only when frame bits 0..5 (bit 0 shifted first) equal `addr_strap[5:0]`. Any other address leaves every register unchanged.
- R3: A frame is 16 bits sampled on rising serial clock edges, least significant bit first. Bits 0..5 are the address, bit 6 selects the channel and bit 7 is reserved and ignored. Bits 8..15 are the data, laid out as power-down at bit 8, algorithm reset at bit 9, bypass at bit 10, data format at bit 11 and coding at bits 12..15.
- R4: A write changes only the channel named by bit 6. The other channel keeps its value.
- R5: Raising `cs_n` before the 16th bit discards the partial frame. The next frame starts again at bit 0.
- R6: Serial clock edges while `cs_n` is high shift nothing and change no register.
- R7: A channel's algorithm-reset bit clears one cycle after its `alrst_done` bit is high. A write to that channel in the same cycle takes priority. Completion for one channel never clears another channel's bit.
- R8: `standby` is high exactly when the power-down bit of every channel is set.
- R9: When `cs_n` stays low after a frame, the bit count wraps and a following 16-bit frame is decoded and applied as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data, least significant bit first |
| addr_strap | input | 6 | Strapped device address |
| alrst_done | input | 2 | Per-channel algorithm-reset completion from the datapath |
| chan_pd | output | 2 | Per-channel power-down flag |
| chan_alrst | output | 2 | Per-channel algorithm-reset request |
| chan_bypass | output | 2 | Per-channel bypass flag |
| chan_fmt | output | 2 | Per-channel data-format flag |
| chan_coding | output | 8 | Per-channel 4-bit coding select, channel 0 in the low nibble |
| standby | output | 1 | All channels powered down |

## Verification
The assertions assume that each serial clock phase lasts at least three system clock cycles, so the synchroniser never misses an edge. They also assume that two complete frames are never decoded on consecutive system cycles, and that `addr_strap` stays static while a frame is in progress. The bench holds every serial clock phase for three system cycles. It changes `sdi` and `cs_n` only while the serial clock is low, and it changes the strap only between frames with the select high.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  // Control register layout, bit 0 is the first data bit on the wire
  typedef struct packed {
    logic [3:0] coding;
    logic       fmt;
    logic       bypass;
    logic       alrst;
    logic       pd;
  } chan_ctrl_t;

  localparam int unsigned CTRL_W = $bits(chan_ctrl_t);
  localparam int unsigned CODE_W = 4;
endpackage

// File: rtl/cfgport_sync.sv
module cfgport_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/cfgport_frame.sv
module cfgport_frame #(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned CH_W    = 1,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned CMD_W   = ADDR_W + CH_W + 1,
  localparam int unsigned FRAME_W = CMD_W + DATA_W,
  localparam int unsigned CNT_W   = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              sdi_s,
  input  logic [ADDR_W-1:0] addr_strap,
  output logic              wr_pulse,
  output logic [CH_W-1:0]   wr_ch,
  output logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic                sclk_d_q;
  logic [FRAME_W-1:0]  shreg_q, shreg_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic                wr_q, wr_n;
  logic [CH_W-1:0]     ch_q, ch_n;
  logic [DATA_W-1:0]   data_q, data_n;
  logic                sclk_rise;
  logic                shift_en;
  logic [FRAME_W-1:0]  word;

  assign sclk_rise = sclk_s & ~sclk_d_q;
  assign shift_en  = sclk_rise & ~cs_n_s;
  assign word      = {sdi_s, shreg_q[FRAME_W-1:1]};

  always_comb begin
    shreg_n = shreg_q;
    cnt_n   = cnt_q;
    wr_n    = 1'b0;
    ch_n    = ch_q;
    data_n  = data_q;
    if (cs_n_s) begin
      cnt_n = '0;
    end else if (shift_en) begin
      shreg_n = word;
      if (cnt_q == LAST_BIT) begin
        cnt_n  = '0;
        wr_n   = (word[ADDR_W-1:0] == addr_strap);
        ch_n   = word[ADDR_W +: CH_W];
        data_n = word[CMD_W +: DATA_W];
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      shreg_q  <= '0;
      cnt_q    <= '0;
      wr_q     <= 1'b0;
      ch_q     <= '0;
      data_q   <= '0;
    end else begin
      sclk_d_q <= sclk_s;
      shreg_q  <= shreg_n;
      cnt_q    <= cnt_n;
      wr_q     <= wr_n;
      ch_q     <= ch_n;
      data_q   <= data_n;
    end
  end

  assign wr_pulse = wr_q;
  assign wr_ch    = ch_q;
  assign wr_data  = data_q;
  assign bit_cnt  = cnt_q;
endmodule

// File: rtl/cfgport_regbank.sv
module cfgport_regbank
  import cfgport_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CH_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [NUM_CH-1:0] alrst_done,
  output chan_ctrl_t        ctrl [NUM_CH]
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    chan_ctrl_t reg_q, reg_n;
    logic       sel;

    assign sel = wr_pulse && (wr_ch == CH_W'(i));

    always_comb begin
      reg_n = reg_q;
      if (sel) begin
        reg_n = chan_ctrl_t'(wr_data);
      end else if (alrst_done[i]) begin
        reg_n.alrst = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q <= '0;
      else if (sel || alrst_done[i]) reg_q <= reg_n;
    end

    assign ctrl[i] = reg_q;
  end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import cfgport_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned CNT_W  = $clog2(ADDR_W + CH_W + 1 + CTRL_W)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       sclk,
  input  logic                       sdi,
  input  logic [ADDR_W-1:0]          addr_strap,
  input  logic [NUM_CH-1:0]          alrst_done,
  output logic [NUM_CH-1:0]          chan_pd,
  output logic [NUM_CH-1:0]          chan_alrst,
  output logic [NUM_CH-1:0]          chan_bypass,
  output logic [NUM_CH-1:0]          chan_fmt,
  output logic [NUM_CH*CODE_W-1:0]   chan_coding,
  output logic                       standby
);
  logic              sclk_s, cs_n_s, sdi_s;
  logic              wr_pulse;
  logic [CH_W-1:0]   wr_ch;
  logic [CTRL_W-1:0] wr_data;
  logic [CNT_W-1:0]  bit_cnt;
  chan_ctrl_t        ctrl [NUM_CH];

  cfgport_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sdi, cs_n, sclk}),
    .q({sdi_s, cs_n_s, sclk_s})
  );

  cfgport_frame #(.ADDR_W(ADDR_W), .CH_W(CH_W), .DATA_W(CTRL_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .cs_n_s(cs_n_s), .sdi_s(sdi_s),
    .addr_strap(addr_strap),
    .wr_pulse(wr_pulse), .wr_ch(wr_ch), .wr_data(wr_data),
    .bit_cnt(bit_cnt)
  );

  cfgport_regbank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_pulse(wr_pulse), .wr_ch(wr_ch), .wr_data(wr_data),
    .alrst_done(alrst_done),
    .ctrl(ctrl)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_out
    assign chan_pd[i]                       = ctrl[i].pd;
    assign chan_alrst[i]                    = ctrl[i].alrst;
    assign chan_bypass[i]                   = ctrl[i].bypass;
    assign chan_fmt[i]                      = ctrl[i].fmt;
    assign chan_coding[i*CODE_W +: CODE_W]  = ctrl[i].coding;
  end

  assign standby = &chan_pd;
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CH_W   = 1,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned CODE_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cs_n_s,
  input logic                     wr_pulse,
  input logic [CH_W-1:0]          wr_ch,
  input logic [CNT_W-1:0]         bit_cnt,
  input logic [NUM_CH-1:0]        alrst_done,
  input logic [NUM_CH-1:0]        chan_pd,
  input logic [NUM_CH-1:0]        chan_alrst,
  input logic [NUM_CH-1:0]        chan_bypass,
  input logic [NUM_CH-1:0]        chan_fmt,
  input logic [NUM_CH*CODE_W-1:0] chan_coding,
  input logic                     standby
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert ((chan_pd | chan_alrst | chan_bypass | chan_fmt) == '0
                                && chan_coding == '0 && !standby);
    end
  end

  p_hold_without_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> $stable(chan_pd) && $stable(chan_bypass) && $stable(chan_fmt) && $stable(chan_coding));

  p_one_write_per_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  p_cs_restarts_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> bit_cnt == '0);

  p_standby_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby) |-> $past(wr_pulse));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    p_alrst_self_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (alrst_done[i] && !(wr_pulse && wr_ch == CH_W'(i))) |=> !chan_alrst[i]);
  end
endmodule

bind serial_cfg_port cfgport_chk #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .CNT_W(CNT_W), .CODE_W(cfgport_pkg::CODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s),
  .wr_pulse(wr_pulse), .wr_ch(wr_ch), .bit_cnt(bit_cnt),
  .alrst_done(alrst_done),
  .chan_pd(chan_pd), .chan_alrst(chan_alrst), .chan_bypass(chan_bypass),
  .chan_fmt(chan_fmt), .chan_coding(chan_coding), .standby(standby)
);

// File: tb/tb_serial_cfg_port.sv
module tb_serial_cfg_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, sclk, sdi;
  logic [5:0] addr_strap;
  logic [1:0] alrst_done;
  logic [1:0] chan_pd, chan_alrst, chan_bypass, chan_fmt;
  logic [7:0] chan_coding;
  logic       standby;

  int vectors = 0;
  int fails   = 0;
  logic [7:0] exp_reg [2];

  always #4 clk = ~clk;

  serial_cfg_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .addr_strap(addr_strap), .alrst_done(alrst_done),
    .chan_pd(chan_pd), .chan_alrst(chan_alrst), .chan_bypass(chan_bypass),
    .chan_fmt(chan_fmt), .chan_coding(chan_coding), .standby(standby)
  );

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  function automatic logic [7:0] act_reg(input int ch);
    return {chan_coding[ch*4 +: 4], chan_fmt[ch], chan_bypass[ch], chan_alrst[ch], chan_pd[ch]};
  endfunction

  task automatic check_all(input string req);
    for (int c = 0; c < 2; c++) begin
      vectors++;
      if (act_reg(c) !== exp_reg[c]) begin
        fails++;
        $display("FAIL %s ch%0d: actual=%h expected=%h", req, c, act_reg(c), exp_reg[c]);
      end
    end
    vectors++;
    if (standby !== (exp_reg[0][0] & exp_reg[1][0])) begin
      fails++;
      $display("FAIL R8 standby: actual=%b expected=%b", standby, exp_reg[0][0] & exp_reg[1][0]);
    end
  endtask

  // shift n bits of w, LSB first, with select low; optionally leave select low
  task automatic shift_bits(input logic [31:0] w, input int n, input bit keep_low);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = w[i];
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (3) @(negedge clk);
    if (!keep_low) cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [15:0] mk_frame(input logic [5:0] a, input bit ch,
                                           input bit rsv, input logic [7:0] d);
    return {d, rsv, ch, a};
  endfunction

  task automatic model_write(input logic [5:0] a, input bit ch, input logic [7:0] d);
    if (a == addr_strap) exp_reg[ch] = d;
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    addr_strap = 6'h2B; alrst_done = 2'b00;
    exp_reg[0] = 8'h00; exp_reg[1] = 8'h00;
    repeat (4) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2, R3, R4: sweep every address, both channels, varied data and reserved bit
    for (int a = 0; a < 64; a++) begin
      for (int ch = 0; ch < 2; ch++) begin
        logic [7:0] d;
        d = 8'(a * 37 + ch * 91 + 5) & 8'hFD;
        shift_bits({16'h0, mk_frame(6'(a), ch[0], a[0], d)}, 16, 1'b0);
        model_write(6'(a), ch[0], d);
        check_all("R2/R3/R4");
      end
    end

    // R2 with other strap values
    for (int s = 0; s < 64; s += 21) begin
      addr_strap = 6'(s);
      repeat (4) @(negedge clk);
      shift_bits({16'h0, mk_frame(6'(s), 1'b0, 1'b1, 8'(s + 8'h5A) & 8'hFD)}, 16, 1'b0);
      model_write(6'(s), 1'b0, 8'(s + 8'h5A) & 8'hFD);
      shift_bits({16'h0, mk_frame(~6'(s), 1'b1, 1'b0, 8'h3C)}, 16, 1'b0);
      check_all("R2");
    end
    addr_strap = 6'h2B;
    repeat (4) @(negedge clk);

    // R5: partial frame aborted by raising select, then a full frame
    shift_bits({16'h0, 16'hFFFF}, 7, 1'b0);
    check_all("R5 partial");
    shift_bits({16'h0, mk_frame(6'h2B, 1'b1, 1'b0, 8'hA4)}, 16, 1'b0);
    model_write(6'h2B, 1'b1, 8'hA4);
    check_all("R5");

    // R6: clock toggling with select high shifts nothing
    for (int i = 0; i < 20; i++) begin
      sdi = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    check_all("R6 idle");
    shift_bits({16'h0, mk_frame(6'h2B, 1'b0, 1'b0, 8'h58)}, 16, 1'b0);
    model_write(6'h2B, 1'b0, 8'h58);
    check_all("R6");

    // R9: two frames back to back in one select period
    shift_bits({mk_frame(6'h2B, 1'b1, 1'b1, 8'h91), mk_frame(6'h2B, 1'b0, 1'b0, 8'h6C)}, 32, 1'b0);
    model_write(6'h2B, 1'b0, 8'h6C);
    model_write(6'h2B, 1'b1, 8'h91);
    check_all("R9");

    // R7: algorithm-reset request held until its own completion
    shift_bits({16'h0, mk_frame(6'h2B, 1'b0, 1'b0, 8'h73)}, 16, 1'b0);
    model_write(6'h2B, 1'b0, 8'h73);
    shift_bits({16'h0, mk_frame(6'h2B, 1'b1, 1'b0, 8'h02)}, 16, 1'b0);
    model_write(6'h2B, 1'b1, 8'h02);
    check_all("R7 set");
    alrst_done = 2'b10;
    @(negedge clk);
    alrst_done = 2'b00;
    exp_reg[1][1] = 1'b0;
    repeat (2) @(negedge clk);
    check_all("R7 ch1 only");
    alrst_done = 2'b01;
    @(negedge clk);
    alrst_done = 2'b00;
    exp_reg[0][1] = 1'b0;
    repeat (2) @(negedge clk);
    check_all("R7 ch0");

    // R8: standby follows both power-down bits
    shift_bits({16'h0, mk_frame(6'h2B, 1'b1, 1'b0, 8'h01)}, 16, 1'b0);
    model_write(6'h2B, 1'b1, 8'h01);
    check_all("R8 both");
    shift_bits({16'h0, mk_frame(6'h2B, 1'b0, 1'b0, 8'h00)}, 16, 1'b0);
    model_write(6'h2B, 1'b0, 8'h00);
    check_all("R8 one");

    // R1: reset again clears everything
    rst_n = 1'b0;
    exp_reg[0] = 8'h00; exp_reg[1] = 8'h00;
    repeat (3) @(negedge clk);
    check_all("R1 again");
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule